// File: doc/BRIEF.md
# Round-Robin Locked Shared-Bus Arbiter

This block models a shared bus used by four processor cores. It decides which core owns the bus and keeps that owner in place until its transfer is complete. Each core raises a request line together with a 3-bit access kind. Grants go out in rotating order. Transfers are never split, so once a core wins, the bus stays locked to it for a fixed number of cycles. That number depends only on the access kind: a short hit, a longer hit, a clean miss or a dirty miss.

The hold time of one core's access therefore sets how long every other core waits. The block makes that delay visible through a free-running wait counter per core. The counter advances on every cycle in which the core asks for the bus and does not hold it. A system model or a timing experiment reads these counters to measure the contention each core suffered. When one hold ends and another core is asking, the bus passes to it on the very next cycle.

Top module: `shared_bus_arb`

## Requirements
- R1: While rst_n is low at a clock edge, and in the cycle after it, grant_o is all zeros, busy_o is 0 and every wait counter is 0.
- R2: grant_o has at most one bit set. A bit only turns on for a core whose request was high in the cycle before.
- R3: Priority rotates. Out of reset core 0 ranks first. After a hold held by core w ends, the next grant goes to the first requesting core found searching upward from w+1 and wrapping round from core 3 to core 0.
- R4: The hold length in cycles is set by the 3-bit kind sampled at the grant edge. Kind 0 (store hit) holds for 1 cycle and kind 1 (load hit) for 8. Kinds 2 and 3 (clean misses, load and store) hold for 28. Kinds 4 and 5 (dirty misses, load and store) hold for 31. The unused codes 6 and 7 also hold for 31.
- R5: During a hold, the grant stays on the same core for the whole hold, whatever the other cores request. A transfer is never cut short or split.
- R6: If any request is high in the last cycle of a hold, the next grant is visible in the very next cycle, with no idle cycle between. If no request is high, the bus goes idle.
- R7: The 32-bit wait counter of core i sits at bits [32*i+31:32*i] of wait_cnt_o. It increases by exactly one after each cycle in which req_i[i] is high and grant_o[i] is low. Otherwise it keeps its value.
- R8: busy_o is high exactly in the cycles in which some grant bit is high.
- R9: A change of a core's kind after its grant has no effect on the length of the hold already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 4 | Per-core bus request; held stable until granted |
| req_type_i | input | 12 | Per-core 3-bit access kind, core i at bits [3*i+2:3*i] |
| grant_o | output | 4 | One-hot bus owner, all zeros when idle |
| busy_o | output | 1 | Bus is locked to some core |
| wait_cnt_o | output | 128 | Per-core 32-bit wait-cycle counters |

## Verification
The bench goes after the hold length of every kind code, the 1-cycle store hit and the two unused codes included. A design with an off-by-one hold timer would show one cycle too many or too few on each of these. With all four cores asking at once, the grants must rotate in order 0, 1, 2, 3 with no idle cycle between them. A design that inserts a bubble after each release fails this, and so does one that resets the rotation pointer. The exact wait counts of 1, 29, 57 and 85 cycles show whether a counter also runs during its own core's grant. A long stretch of pseudo-random traffic then exercises further cases. Some cores keep their request alive through their own hold, which checks that they can win again. Other cores change their kind in the middle of a hold, which a design that re-reads the kind would mishandle.

// File: rtl/bus_arb_pkg.sv
// Package: shared definitions for the locked shared-bus arbiter.
// Holds the access-kind encoding that requesters drive on req_type_i.
package bus_arb_pkg;

    localparam int KIND_W = 3;

    // Access kinds; codes 6 and 7 are unused and map to the longest hold.
    typedef enum logic [KIND_W-1:0] {
        KIND_ST_HIT    = 3'd0,
        KIND_LD_HIT    = 3'd1,
        KIND_LD_CLEAN  = 3'd2,
        KIND_ST_CLEAN  = 3'd3,
        KIND_LD_DIRTY  = 3'd4,
        KIND_ST_DIRTY  = 3'd5,
        KIND_RSVD6     = 3'd6,
        KIND_RSVD7     = 3'd7
    } bus_kind_e;

endpackage

// File: rtl/bus_lat_map.sv
// Module: bus_lat_map
// Maps an access kind to the number of cycles the bus stays locked.
// Assumes all latencies are at least 1 and fit in HOLD_W bits.
module bus_lat_map
    import bus_arb_pkg::*;
#(
    parameter int LAT_HIT_ST = 1,
    parameter int LAT_HIT_LD = 8,
    parameter int LAT_CLEAN  = 28,
    parameter int LAT_DIRTY  = 31,
    parameter int HOLD_W     = 5
) (
    input  logic [KIND_W-1:0] kind_i,
    output logic [HOLD_W-1:0] cycles_o
);

    // Purpose: pure lookup of hold length; unused codes take the worst case.
    always_comb begin
        case (bus_kind_e'(kind_i))
            KIND_ST_HIT:                  cycles_o = HOLD_W'(LAT_HIT_ST);
            KIND_LD_HIT:                  cycles_o = HOLD_W'(LAT_HIT_LD);
            KIND_LD_CLEAN, KIND_ST_CLEAN: cycles_o = HOLD_W'(LAT_CLEAN);
            default:                      cycles_o = HOLD_W'(LAT_DIRTY);
        endcase
    end

endmodule

// File: rtl/bus_rr_pick.sv
// Module: bus_rr_pick
// Combinational round-robin selector: finds the first set request at or
// after the pointer, wrapping at NUM_REQ. Assumes ptr_i < NUM_REQ.
module bus_rr_pick #(
    parameter int NUM_REQ = 4,
    parameter int PTR_W   = 2
) (
    input  logic [NUM_REQ-1:0] req_i,
    input  logic [PTR_W-1:0]   ptr_i,
    output logic               found_o,
    output logic [PTR_W-1:0]   idx_o,
    output logic [NUM_REQ-1:0] onehot_o
);

    // Purpose: scan requests from the pointer upward and take the first hit.
    always_comb begin
        found_o  = 1'b0;
        idx_o    = '0;
        onehot_o = '0;
        for (int k = 0; k < NUM_REQ; k++) begin
            int j;
            j = int'(ptr_i) + k;
            if (j >= NUM_REQ) j = j - NUM_REQ;
            if (!found_o && req_i[j]) begin
                found_o     = 1'b1;
                idx_o       = PTR_W'(j);
                onehot_o[j] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bus_hold_timer.sv
// Module: bus_hold_timer
// Down-counter that tracks the cycles left in the current bus hold.
// Loaded with (hold length - 1) at the grant edge; last_o flags zero.
module bus_hold_timer #(
    parameter int HOLD_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [HOLD_W-1:0] len_i,
    output logic              last_o
);

    logic [HOLD_W-1:0] left_q;

    // Purpose: load on a new grant, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load_i) begin
            left_q <= len_i - HOLD_W'(1);
        end else if (left_q != '0) begin
            left_q <= left_q - HOLD_W'(1);
        end
    end

    assign last_o = (left_q == '0);

endmodule

// File: rtl/bus_wait_ctr.sv
// Module: bus_wait_ctr
// Per-core contention counter: advances while the core waits for the bus.
// Wraps at 2**CNT_W; cleared only by reset.
module bus_wait_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             waiting_i,
    output logic [CNT_W-1:0] count_o
);

    // Purpose: add one for every cycle spent waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (waiting_i) begin
            count_o <= count_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/shared_bus_arb.sv
// Module: shared_bus_arb
// Round-robin arbiter for a non-split shared bus. The winner keeps the bus
// for a kind-dependent number of cycles; the next grant may follow at once.
// Assumes each requester holds req and kind stable until granted.
module shared_bus_arb
    import bus_arb_pkg::*;
#(
    parameter int NUM_REQ    = 4,
    parameter int CNT_W      = 32,
    parameter int LAT_HIT_ST = 1,
    parameter int LAT_HIT_LD = 8,
    parameter int LAT_CLEAN  = 28,
    parameter int LAT_DIRTY  = 31
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_REQ-1:0]         req_i,
    input  logic [NUM_REQ*KIND_W-1:0]  req_type_i,
    output logic [NUM_REQ-1:0]         grant_o,
    output logic                       busy_o,
    output logic [NUM_REQ*CNT_W-1:0]   wait_cnt_o
);

    localparam int PTR_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
    localparam int MAX_LAT = (LAT_DIRTY > LAT_CLEAN) ? LAT_DIRTY : LAT_CLEAN;
    localparam int HOLD_W  = $clog2(MAX_LAT + 1);

    logic [PTR_W-1:0]   ptr_q;
    logic [NUM_REQ-1:0] grant_q;
    logic               win_found;
    logic [PTR_W-1:0]   win_idx;
    logic [NUM_REQ-1:0] win_onehot;
    logic [KIND_W-1:0]  win_kind;
    logic [HOLD_W-1:0]  win_len;
    logic               hold_last;
    logic               may_issue;
    logic               issue;

    bus_rr_pick #(
        .NUM_REQ (NUM_REQ),
        .PTR_W   (PTR_W)
    ) pick_i (
        .req_i    (req_i),
        .ptr_i    (ptr_q),
        .found_o  (win_found),
        .idx_o    (win_idx),
        .onehot_o (win_onehot)
    );

    // Purpose: select the access kind of the current candidate.
    always_comb begin
        win_kind = req_type_i[win_idx*KIND_W +: KIND_W];
    end

    bus_lat_map #(
        .LAT_HIT_ST (LAT_HIT_ST),
        .LAT_HIT_LD (LAT_HIT_LD),
        .LAT_CLEAN  (LAT_CLEAN),
        .LAT_DIRTY  (LAT_DIRTY),
        .HOLD_W     (HOLD_W)
    ) lat_i (
        .kind_i   (win_kind),
        .cycles_o (win_len)
    );

    // Arbitration opens when idle or in the final cycle of a hold.
    assign may_issue = !busy_o || hold_last;
    assign issue     = may_issue && win_found;

    bus_hold_timer #(
        .HOLD_W (HOLD_W)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (issue),
        .len_i  (win_len),
        .last_o (hold_last)
    );

    // Purpose: register the grant and advance the pointer past each winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            ptr_q   <= '0;
        end else if (may_issue) begin
            grant_q <= win_found ? win_onehot : '0;
            if (win_found) begin
                ptr_q <= (win_idx == PTR_W'(NUM_REQ - 1)) ? '0 : win_idx + PTR_W'(1);
            end
        end
    end

    assign grant_o = grant_q;
    assign busy_o  = |grant_q;

    generate
        for (genvar g = 0; g < NUM_REQ; g++) begin : g_wait
            bus_wait_ctr #(
                .CNT_W (CNT_W)
            ) ctr_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .waiting_i (req_i[g] && !grant_q[g]),
                .count_o   (wait_cnt_o[g*CNT_W +: CNT_W])
            );
        end
    endgenerate

endmodule

// File: rtl/shared_bus_arb_chk.sv
// Module: shared_bus_arb_chk
// Property checker bound to shared_bus_arb. Tracks hold lengths with its
// own run counter and checks grant shape, hold timing and wait counting.
module shared_bus_arb_chk #(
    parameter int NUM_REQ    = 4,
    parameter int CNT_W      = 32,
    parameter int LAT_HIT_ST = 1,
    parameter int LAT_HIT_LD = 8,
    parameter int LAT_CLEAN  = 28,
    parameter int LAT_DIRTY  = 31
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_REQ-1:0]        req_i,
    input logic [NUM_REQ*3-1:0]      req_type_i,
    input logic [NUM_REQ-1:0]        grant_o,
    input logic                      busy_o,
    input logic [NUM_REQ*CNT_W-1:0]  wait_cnt_o
);

    logic [NUM_REQ-1:0]   prev_grant_q;
    logic [NUM_REQ*3-1:0] prev_kind_q;
    int                   run_q, lat_q, run_now, lat_now;
    logic                 start_now;

    function automatic int kind_len(input logic [2:0] k);
        if (k == 3'd0)      return LAT_HIT_ST;
        else if (k == 3'd1) return LAT_HIT_LD;
        else if (k == 3'd2 || k == 3'd3) return LAT_CLEAN;
        else                return LAT_DIRTY;
    endfunction

    // Purpose: decide whether this cycle starts a hold and its expected length.
    always_comb begin
        start_now = (grant_o != '0) && ((run_q == lat_q) || (grant_o != prev_grant_q));
        lat_now   = lat_q;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (start_now && grant_o[i]) lat_now = kind_len(prev_kind_q[i*3 +: 3]);
        end
        run_now = start_now ? 1 : run_q + 1;
    end

    // Purpose: remember last cycle's grant, kinds and hold progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_grant_q <= '0;
            prev_kind_q  <= '0;
            run_q        <= 0;
            lat_q        <= 0;
        end else begin
            prev_grant_q <= grant_o;
            prev_kind_q  <= req_type_i;
            run_q        <= (grant_o != '0) ? run_now : 0;
            lat_q        <= (grant_o != '0) ? lat_now : 0;
        end
    end

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R2
    grant_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o & ~prev_grant_q) != '0) |-> ((grant_o & $past(req_i)) != '0));

    // R8
    busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == (grant_o != '0));

    // R4 R5
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((prev_grant_q != '0) && (grant_o != prev_grant_q)) |-> (run_q == lat_q));

    // R4
    hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0) |-> (run_now <= lat_now));

    // R6
    back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (run_now == lat_now) && (req_i != '0)) |=> busy_o);

    generate
        for (genvar g = 0; g < NUM_REQ; g++) begin : g_wait_chk
            // R7
            wait_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (req_i[g] && !grant_o[g]) |=>
                (wait_cnt_o[g*CNT_W +: CNT_W] == $past(wait_cnt_o[g*CNT_W +: CNT_W]) + CNT_W'(1)));
            // R7
            wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(req_i[g] && !grant_o[g]) |=>
                $stable(wait_cnt_o[g*CNT_W +: CNT_W]));
        end
    endgenerate

endmodule

bind shared_bus_arb shared_bus_arb_chk #(
    .NUM_REQ    (NUM_REQ),
    .CNT_W      (CNT_W),
    .LAT_HIT_ST (LAT_HIT_ST),
    .LAT_HIT_LD (LAT_HIT_LD),
    .LAT_CLEAN  (LAT_CLEAN),
    .LAT_DIRTY  (LAT_DIRTY)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .req_type_i (req_type_i),
    .grant_o    (grant_o),
    .busy_o     (busy_o),
    .wait_cnt_o (wait_cnt_o)
);

// File: tb/shared_bus_arb_tb_top.sv
// Bench: behavioural reference model compared every cycle, plus directed
// hold-length, rotation and wait-count checks.
module shared_bus_arb_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   req = '0;
    logic [11:0]  kind = '0;
    logic [3:0]   grant;
    logic         busy;
    logic [127:0] waits;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int cyc = 0;

    // reference model state
    int m_holder = -1;
    int m_left = 0;
    int m_ptr = 0;
    int m_wait[4] = '{0, 0, 0, 0};
    bit compare_on = 0;

    int unsigned rng = 32'h1234_5678;

    shared_bus_arb dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .req_type_i (kind),
        .grant_o    (grant),
        .busy_o     (busy),
        .wait_cnt_o (waits)
    );

    always #2 clk = ~clk;

    function automatic int hold_of(input int k);
        case (k)
            0: return 1;
            1: return 8;
            2, 3: return 28;
            default: return 31;
        endcase
    endfunction

    function automatic int unsigned next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // reference model: advances on every clock edge from the sampled inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_holder = -1; m_left = 0; m_ptr = 0;
            for (int i = 0; i < 4; i++) m_wait[i] = 0;
        end else begin
            bit open;
            for (int i = 0; i < 4; i++)
                if (req[i] && m_holder != i) m_wait[i] = m_wait[i] + 1;
            open = (m_holder < 0) || (m_left == 1);
            if (m_holder >= 0) m_left = m_left - 1;
            if (open) begin
                m_holder = -1;
                for (int k = 0; k < 4; k++) begin
                    int j;
                    j = (m_ptr + k) % 4;
                    if (m_holder < 0 && req[j]) begin
                        m_holder = j;
                        m_left = hold_of(int'(kind[j*3 +: 3]));
                    end
                end
                if (m_holder >= 0) m_ptr = (m_holder + 1) % 4;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (compare_on) begin
            logic [3:0] exp_g;
            exp_g = (m_holder >= 0) ? (4'b1 << m_holder) : 4'b0;
            chk("R2/R3/R5 grant", grant, exp_g);
            chk("R8 busy", busy, exp_g != 0);
            for (int i = 0; i < 4; i++)
                chk("R7 wait counter", waits[i*32 +: 32], m_wait[i]);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic single(input int c, input int k, input int exp_len, input bit swap);
        int n = 0;
        bit got = 0;
        @(negedge clk);
        req[c] = 1'b1;
        kind[c*3 +: 3] = 3'(k);
        forever begin
            @(negedge clk);
            if (grant[c]) begin
                n++;
                if (!got) begin
                    got = 1;
                    req[c] = 1'b0;
                    if (swap) kind[c*3 +: 3] = 3'd0;  // R9: ignored mid-hold
                end
            end else if (got) break;
        end
        if (swap) chk("R9 hold after kind change", n, exp_len);
        else      chk("R4 hold length", n, exp_len);
    endtask

    initial begin
        int base[4];
        int order[$];
        int idle;
        bit seen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 grant after reset", grant, 0);
        chk("R1 busy after reset", busy, 0);
        chk("R1 wait counters after reset", waits == '0, 1);
        compare_on = 1;

        // R4 / R9: every kind code, alone on the bus
        for (int k = 0; k < 8; k++) single(k % 4, k, hold_of(k), 1'b0);
        single(1, 1, 8, 1'b1);
        single(3, 5, 31, 1'b1);

        // R3 / R6 / R7: all four at once, kind 2 (28 cycles); pointer at core 0
        for (int i = 0; i < 4; i++) base[i] = int'(waits[i*32 +: 32]);
        @(negedge clk);
        req = 4'hF;
        kind = {4{3'd2}};
        idle = 0;
        seen = 0;
        while (order.size() < 4) begin
            @(negedge clk);
            if (seen && !busy) idle++;
            for (int i = 0; i < 4; i++)
                if (grant[i] && req[i]) begin
                    order.push_back(i);
                    req[i] = 1'b0;
                    seen = 1;
                end
        end
        while (busy) @(negedge clk);
        for (int i = 0; i < 4; i++) chk("R3 rotation order", order[i], i);
        chk("R6 idle cycles between holds", idle, 0);
        for (int i = 0; i < 4; i++)
            chk("R7 wait in burst", int'(waits[i*32 +: 32]) - base[i], 1 + 28 * i);

        // pseudo-random traffic, model compared every cycle
        for (int t = 0; t < 4000; t++) begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) begin
                int unsigned r;
                r = next_rand();
                if (req[i] && grant[i]) begin
                    if (r[1:0] == 2'd0) kind[i*3 +: 3] = 3'(r[10:8]);
                    else req[i] = 1'b0;
                end else if (!req[i] && r[3:2] == 2'd0) begin
                    req[i] = 1'b1;
                    kind[i*3 +: 3] = 3'(r[10:8]);
                end
            end
        end
        // drain
        for (int t = 0; t < 400; t++) begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) if (grant[i]) req[i] = 1'b0;
        end
        chk("R6 bus idle after drain", busy, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule